// File: doc/BRIEF.md
# Dual-Clock Queue with Rewind

This block is a first-in first-out queue whose write side and read side each run on their own clock. Words enter on the write clock when the write enable is high and leave on the read clock. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other clock domain through a chain of synchronizer flops. Fullness and the half-full flag are worked out on the write side. Emptiness is worked out on the read side.

A configuration is captured while the master reset is held low. It has two parts:
- **Read mode.** In standard mode a word reaches the output only when it is requested. In fall-through mode the oldest stored word is presented on the output without any request.
- **Rewind latency.** A rewind strobe moves the read pointer back to storage location zero, so every stored word can be read again. With zero latency, the word at location zero is on the output right after the strobe edge. With normal latency, it arrives through the usual read path.

A partial reset clears both pointers but keeps the captured configuration. Two status pins change meaning with the read mode.

Top module: `dcq_retx`

## Requirements
- R1: Words written on `wr_clk` come out on `rd_clk` in the order they were written, with the two clocks unrelated in frequency. A Gray-coded pointer changes by at most one bit per clock in its own domain.
- R2: While `mrst_n` is low, both pointers are cleared. The read mode is loaded from `cfg_fwft` (0 = standard, 1 = fall-through). The rewind latency is loaded from `cfg_retx_zero` (0 = normal, 1 = zero).
- R3: While `prst_n` is low and `mrst_n` is high, both pointers are cleared. The read mode and rewind latency keep the values captured at the last master reset, whatever `cfg_fwft` and `cfg_retx_zero` carry.
- R4: In fall-through mode, the first stored word appears on `rd_data` with `out_stat` = 1 and no `rd_en`. Each following word appears one `rd_clk` edge after `rd_en` is sampled high. `out_stat` falls when the presented word is taken and nothing further is stored.
- R5: In standard mode, `in_stat` = 1 means full and `out_stat` = 1 means empty. In fall-through mode, `in_stat` = 1 means room to accept a word and `out_stat` = 1 means `rd_data` holds a valid word.
- R6: In standard mode, `rd_data` changes only on a `rd_clk` edge where `rd_en` is high and a word is stored. It then takes the oldest unread word. Otherwise it holds.
- R7: A `retx` sampled high on a `rd_clk` edge moves the read pointer to location zero. The next words read are those written first since the last pointer clear. `retx` takes priority over `rd_en` in the same cycle.
- R8: A write while full and a read with nothing to deliver have no effect: the pointers and `rd_data` keep their values.
- R9: `half_flag` is 1 exactly when the write side sees more than half the depth occupied (with the default depth of 8: five or more words). This holds in both read modes.
- R10: With zero latency, the edge that samples `retx` also loads `rd_data` with the word at location zero. In fall-through mode, `out_stat` stays 1 across that edge. With normal latency, `rd_data` keeps its value at that edge. In fall-through mode, `out_stat` drops to 0 for one `rd_clk` cycle and the location-zero word is presented on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks; captures configuration |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks; keeps configuration |
| cfg_fwft | input | 1 | Read mode captured at master reset: 1 fall-through, 0 standard |
| cfg_retx_zero | input | 1 | Rewind latency captured at master reset: 1 zero, 0 normal |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| in_stat | output | 1 | Full (standard) or ready to accept (fall-through) |
| half_flag | output | 1 | More than half the depth occupied |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Rewind strobe |
| rd_data | output | DATA_W | Output word register |
| out_stat | output | 1 | Empty (standard) or output valid (fall-through) |

## Verification
The rewind strobe and a read request can arrive on the same read-clock edge, and the rewind must win. The bench provokes this in standard mode with normal latency: it holds `rd_en` and `retx` high together after the queue has been drained once. It then checks two things. First, `rd_data` still shows the last word read, so the read was dropped. Second, the next plain read returns the first word ever written rather than a later one. A second pairing is a write attempt while full followed later by a full drain, which must never deliver the rejected word.

// File: rtl/dcq_pkg.sv
// Shared types for the dual-clock rewindable queue.
// Assumes: configuration is captured only during master reset.
package dcq_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef enum logic {
        RETX_NORMAL = 1'b0,
        RETX_ZERO   = 1'b1
    } retx_lat_e;

    typedef struct packed {
        rd_mode_e  mode;
        retx_lat_e lat;
    } dcq_cfg_t;

endpackage

// File: rtl/dcq_store.sv
// Storage array: one synchronous write port, one combinational read port.
// Assumes: addresses are already reduced to the array range.
module dcq_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word without a clock.
    assign rdata = mem[raddr];

endmodule

// File: rtl/dcq_ptr_xing.sv
// Carries a Gray-coded pointer into another clock domain through a flop
// chain and returns it in binary.
// Assumes: the source changes at most one bit per source clock.
module dcq_ptr_xing #(
    parameter int PTR_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);
    logic [PTR_W-1:0] stg [STAGES];

    // First synchronizer flop samples the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= gray_in;
    end

    // Remaining flops of the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            bin_out[i] = ^(stg[STAGES-1] >> i);
        end
    end

endmodule

// File: rtl/dcq_wside.sv
// Write-domain control: write pointer, full decision, half-full flag and
// the input status pin.
// Assumes: resets are synchronous to wr_clk and held for several cycles.
module dcq_wside
    import dcq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  dcq_cfg_t         cfg_in,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] rsync_bin,
    output logic [PTR_W-1:0] wbin,
    output logic [PTR_W-1:0] wgray,
    output logic             we,
    output logic             in_stat,
    output logic             half_flag
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;
    localparam logic [PTR_W-1:0] HALF_P  = DEPTH_P >> 1;

    rd_mode_e         mode_q;
    logic [PTR_W-1:0] occ;
    logic [PTR_W-1:0] wbin_nxt;
    logic             full;

    assign occ       = wbin - rsync_bin;
    assign full      = (occ >= DEPTH_P);
    assign we        = wr_en && !full;
    assign wbin_nxt  = wbin + 1'b1;
    assign half_flag = (occ > HALF_P);
    assign in_stat   = (mode_q == MODE_FWFT) ? !full : full;

    // Capture the read mode only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode_q <= cfg_in.mode;
    end

    // Advance the write pointer on each accepted word.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    assert_full_write_dropped_R8: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (wr_en && full) |=> $stable(wbin));

    assert_gray_single_step_R1: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_mrst_clears_wptr_R2: assert property (@(posedge clk)
        !mrst_n |=> (wbin == '0));

    assert_prst_clears_wptr_R3: assert property (@(posedge clk)
        (mrst_n && !prst_n) |=> (wbin == '0 && wgray == '0));

endmodule

// File: rtl/dcq_rside.sv
// Read-domain control: read pointer, output register, fall-through
// prefetch, rewind handling and the output status pin.
// Assumes: rewind is used only while fewer than a full depth of words
// have been written since the last pointer clear.
module dcq_rside
    import dcq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  dcq_cfg_t          cfg_in,
    input  logic              rd_en,
    input  logic              retx,
    input  logic [PTR_W-1:0]  wsync_bin,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_stat
);
    rd_mode_e         mode_q;
    retx_lat_e        lat_q;
    logic [PTR_W-1:0] rbin, rbin_nxt;
    logic             vld, vld_nxt;
    logic             fwft, mem_empty, zero_retx, fetch, load;

    assign fwft      = (mode_q == MODE_FWFT);
    assign mem_empty = (rbin == wsync_bin);
    assign zero_retx = retx && (lat_q == RETX_ZERO) && (wsync_bin != '0);
    assign fetch     = !retx && !mem_empty && (fwft ? (!vld || rd_en) : rd_en);
    assign load      = zero_retx || fetch;
    assign raddr     = zero_retx ? '0 : rbin[ADDR_W-1:0];
    assign out_stat  = fwft ? vld : mem_empty;

    // Next read pointer and output-valid state; rewind wins over reads.
    always_comb begin
        rbin_nxt = rbin;
        vld_nxt  = vld;
        if (retx) begin
            rbin_nxt = zero_retx ? PTR_W'(1) : '0;
            vld_nxt  = fwft && zero_retx;
        end else if (fetch) begin
            rbin_nxt = rbin + 1'b1;
            vld_nxt  = fwft;
        end else if (rd_en) begin
            vld_nxt  = 1'b0;
        end
    end

    // Capture mode and rewind latency only during master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= cfg_in.mode;
            lat_q  <= cfg_in.lat;
        end
    end

    // Pointer, valid bit and output word register.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            vld     <= 1'b0;
            rd_data <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            vld   <= vld_nxt;
            if (load) rd_data <= mem_q;
        end
    end

    assert_empty_read_dropped_R8: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (rd_en && !retx && !fwft && mem_empty) |=> ($stable(rbin) && $stable(rd_data)));

    assert_std_hold_R6: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (!fwft && !rd_en && !retx) |=> ($stable(rd_data) && $stable(rbin)));

    assert_fwft_hold_R4: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (fwft && vld && !rd_en && !retx) |=> (vld && $stable(rd_data)));

    assert_retx_rewind_R7: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (retx && lat_q == RETX_NORMAL) |=> (rbin == '0));

    assert_normal_retx_holds_R10: assert property (@(posedge clk)
        disable iff (!mrst_n || !prst_n)
        (retx && lat_q == RETX_NORMAL) |=> ($stable(rd_data) && !vld));

    assert_mrst_clears_rptr_R2: assert property (@(posedge clk)
        !mrst_n |=> (rbin == '0 && !vld));

endmodule

// File: rtl/dcq_retx.sv
// Top level of the dual-clock queue with rewind. Joins the write-domain
// control, read-domain control, the two pointer crossings and storage.
// Assumes: both resets are held low for several cycles of each clock.
module dcq_retx
    import dcq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              cfg_fwft,
    input  logic              cfg_retx_zero,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_stat,
    output logic              half_flag,
    input  logic              rd_en,
    input  logic              retx,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_stat
);
    localparam int PTR_W = ADDR_W + 1;

    dcq_cfg_t          cfg_in;
    logic              rst_any_n;
    logic [PTR_W-1:0]  wbin, wgray, rgray, wsync_bin, rsync_bin;
    logic              we;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_q;

    assign cfg_in.mode = rd_mode_e'(cfg_fwft);
    assign cfg_in.lat  = retx_lat_e'(cfg_retx_zero);
    assign rst_any_n   = mrst_n && prst_n;

    dcq_wside #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wside (
        .clk       (wr_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .cfg_in    (cfg_in),
        .wr_en     (wr_en),
        .rsync_bin (rsync_bin),
        .wbin      (wbin),
        .wgray     (wgray),
        .we        (we),
        .in_stat   (in_stat),
        .half_flag (half_flag)
    );

    dcq_ptr_xing #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_any_n),
        .gray_in (wgray),
        .bin_out (wsync_bin)
    );

    dcq_ptr_xing #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_any_n),
        .gray_in (rgray),
        .bin_out (rsync_bin)
    );

    dcq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (wbin[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dcq_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rside (
        .clk       (rd_clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .cfg_in    (cfg_in),
        .rd_en     (rd_en),
        .retx      (retx),
        .wsync_bin (wsync_bin),
        .mem_q     (mem_q),
        .raddr     (raddr),
        .rgray     (rgray),
        .rd_data   (rd_data),
        .out_stat  (out_stat)
    );

endmodule

// File: tb/sim_dcq_retx.sv
// Bench for dcq_retx: a table of words walked by one loop through write
// and read phases, then directed tests for modes, resets and rewind.
module sim_dcq_retx;
    localparam int DW = 8;

    localparam logic [DW-1:0] VEC [8] = '{8'h11, 8'h2C, 8'h35, 8'h4A,
                                          8'h5F, 8'h60, 8'h7E, 8'h83};

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1;
    logic cfg_fwft = 1'b0, cfg_retx_zero = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic in_stat, half_flag, out_stat;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dcq_retx u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_retx_zero(cfg_retx_zero),
        .wr_en(wr_en), .wr_data(wr_data), .in_stat(in_stat), .half_flag(half_flag),
        .rd_en(rd_en), .retx(retx), .rd_data(rd_data), .out_stat(out_stat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset(input bit master, input bit fwft, input bit zero);
        @(negedge wr_clk);
        cfg_fwft = fwft; cfg_retx_zero = zero;
        if (master) mrst_n = 1'b0; else prst_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        mrst_n = 1'b1; prst_n = 1'b1;
        cfg_fwft = ~fwft; cfg_retx_zero = ~zero;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    task automatic retx_pulse(input bit with_read);
        @(negedge rd_clk); retx = 1'b1; rd_en = with_read;
        @(negedge rd_clk); retx = 1'b0; rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Standard mode, normal rewind latency.
        hold_reset(1'b1, 1'b0, 1'b0);
        check("R2 std reset out_stat empty", out_stat, 1);
        check("R5 std reset in_stat not full", in_stat, 0);
        check("R9 reset half", half_flag, 0);
        check("R2 reset rd_data", rd_data, 0);

        // One loop over the table: eight writes then eight reads.
        for (int i = 0; i < 16; i++) begin
            if (i < 8) begin
                wr_word(VEC[i]);
                if (i == 3) check("R9 four words half low", half_flag, 0);
                if (i == 4) check("R9 five words half high", half_flag, 1);
            end else begin
                if (i == 8) begin
                    check("R5 std full after depth", in_stat, 1);
                    wr_word(8'hEE);
                    settle();
                    check("R5 std not empty", out_stat, 0);
                    check("R6 no read no change", rd_data, 0);
                end
                rd_pulse();
                check("R1 R6 order", rd_data, VEC[i-8]);
            end
        end
        settle();
        check("R8 rejected word never delivered, empty", out_stat, 1);
        check("R5 std in_stat after drain", in_stat, 0);
        check("R9 half low after drain", half_flag, 0);
        rd_pulse();
        check("R8 read while empty holds", rd_data, VEC[7]);

        // Rewind with a read in the same cycle: rewind wins, data holds.
        retx_pulse(1'b1);
        check("R10 normal latency holds rd_data", rd_data, VEC[7]);
        check("R7 rewind makes words available", out_stat, 0);
        rd_pulse();
        check("R7 first word after rewind", rd_data, VEC[0]);
        rd_pulse();
        check("R7 second word after rewind", rd_data, VEC[1]);

        // Fall-through mode, zero rewind latency.
        hold_reset(1'b1, 1'b1, 1'b1);
        check("R2 R5 fwft out_stat not valid", out_stat, 0);
        check("R5 fwft in_stat ready", in_stat, 1);
        for (int k = 0; k < 3; k++) wr_word(VEC[k]);
        settle();
        check("R4 first word falls through", rd_data, VEC[0]);
        check("R4 out_stat valid", out_stat, 1);
        rd_pulse();
        check("R4 second word", rd_data, VEC[1]);
        rd_pulse();
        check("R4 third word", rd_data, VEC[2]);
        rd_pulse();
        check("R4 out_stat drops when drained", out_stat, 0);
        rd_pulse();
        check("R8 fwft read with nothing holds", rd_data, VEC[2]);
        retx_pulse(1'b0);
        check("R10 zero latency word", rd_data, VEC[0]);
        check("R10 zero latency valid kept", out_stat, 1);
        rd_pulse();
        check("R7 next after zero rewind", rd_data, VEC[1]);
        for (int k = 3; k < 8; k++) wr_word(VEC[k]);
        settle();
        check("R9 half in fwft", half_flag, 1);

        // Partial reset with opposite configuration inputs: mode kept.
        hold_reset(1'b0, 1'b0, 1'b0);
        check("R3 fwft kept in_stat ready", in_stat, 1);
        check("R3 fwft kept out_stat", out_stat, 0);
        check("R3 pointers cleared half", half_flag, 0);
        wr_word(VEC[5]);
        settle();
        check("R3 zero latency kept, fall-through", rd_data, VEC[5]);

        // Fall-through, normal rewind latency.
        hold_reset(1'b1, 1'b1, 1'b0);
        wr_word(VEC[0]); wr_word(VEC[1]);
        settle();
        rd_pulse();
        check("R4 fwft read", rd_data, VEC[1]);
        retx_pulse(1'b0);
        check("R10 normal latency drops valid", out_stat, 0);
        @(negedge rd_clk);
        check("R10 normal latency valid returns", out_stat, 1);
        check("R10 normal latency word zero", rd_data, VEC[0]);

        // Master reset back to standard mode.
        hold_reset(1'b1, 1'b0, 1'b0);
        check("R2 std restored in_stat", in_stat, 0);
        check("R2 std restored out_stat", out_stat, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule